// File: doc/BRIEF.md
# SDRAM Host-Scheduled Command Sequencer

This block turns single-cycle requests from a host into timed SDRAM command sequences. It never refreshes or opens pages by itself. The host asks for each operation when its own schedule calls for it. The operations are device initialisation, a refresh burst, a page open for reading, a page open for writing, entering power-down and leaving power-down. While a sequence runs, the block raises a busy flag and accepts no other request.

Each sequence starts with a precharge of all banks. The block then issues refreshes, a mode-register load or row activations. Parameters give the spacing between commands as a number of controller clock cycles. A page open activates the same row in every bank, taking the row from a 32-bit parameter word. When the open finishes, a flag records whether the page was opened for reading or for writing. A datapath outside this block uses that flag to stream reads or writes. Power-down drops the clock enable. While the device is powered down, every request except power-up is ignored and reported on an error output.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: mode load 0000, refresh 0001, precharge 0010, activate 0011 and NOP 0111. In every cycle that carries no command, the block drives NOP. Address and bank are zero on NOP and refresh cycles.
- R2: An accepted init request issues four commands:
  - a precharge-all in the first cycle after the accepting edge;
  - a refresh T_RP cycles after the precharge;
  - a second refresh T_RFC cycles after the first;
  - a mode load T_RFC cycles after the second refresh, with the mode_cfg value on the address and zero on the bank.
- R3: An accepted refresh request issues a precharge-all, then eight refreshes. The first refresh comes T_RP cycles after the precharge, and each later refresh comes T_RFC cycles after the one before it.
- R4: A precharge always drives address bit 10 high and all other address bits zero. An accepted open request (read or write) follows the precharge with activates to banks 0, 1, 2 and 3 in that order. The first activate comes T_RP cycles after the precharge, and the activates are T_RCD cycles apart. Each activate carries param_word[23:12] as its row. Bits [11:0] of the parameter word do not affect the command pins.
- R5: busy rises together with the precharge. It stays high for T_RP + 2·T_RFC + T_MRD cycles for init, T_RP + 8·T_RFC for refresh and T_RP + 4·T_RCD for an open. Any request that arrives while busy is high has no effect.
- R6: When several requests arrive in the same cycle while idle, only one takes effect. The priority, highest first, is init, refresh, open-read, open-write, power-down.
- R7: In the cycle after an open sequence ends, rd_open or wr_open rises, according to the kind of open. Both flags are low while any sequence runs and after power-down. The flags are never high together.
- R8: An accepted power-down drives sd_cke low from the next cycle on. In power-down, a power-up request drives sd_cke high from the next cycle and returns the block to idle. A power-up request while idle has no effect.
- R9: During power-down, any request other than power-up is ignored. Such a request makes pd_err high for exactly the next cycle, even when a power-up arrives in the same cycle.
- R10: After reset, the block drives NOP, zero address and bank, sd_cke high, and busy, pd_err, rd_open and wr_open low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_init | input | 1 | Request pulse: initialisation |
| cmd_refresh | input | 1 | Request pulse: refresh burst |
| cmd_open_rd | input | 1 | Request pulse: open row for reading |
| cmd_open_wr | input | 1 | Request pulse: open row for writing |
| cmd_pwr_down | input | 1 | Request pulse: enter power-down |
| cmd_pwr_up | input | 1 | Request pulse: leave power-down |
| param_word | input | 32 | Row [23:12], bank [11:10], column [9:0] |
| mode_cfg | input | 12 | Value driven on the address during the mode load |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | 12 | SDRAM address |
| sd_ba | output | 2 | SDRAM bank select |
| sd_cke | output | 1 | SDRAM clock enable |
| busy | output | 1 | A command sequence is in progress |
| pd_err | output | 1 | One-cycle pulse: request ignored during power-down |
| rd_open | output | 1 | A row is open for reading |
| wr_open | output | 1 | A row is open for writing |

## Verification
Two things can coincide in one cycle. The first is a new request landing on a running sequence, including the sequence's final cycle, when busy is about to fall. The bench provokes this by injecting random request masks at random offsets inside every sequence. The trace must then match an undisturbed one cycle by cycle. The second is a power-up that arrives together with other requests while the device is powered down. The bench judges this by requiring sd_cke to rise and pd_err to pulse in the same cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PDN} seq_state_e;
    typedef enum logic [1:0] {K_INIT, K_REF, K_ORD, K_OWR} seq_kind_e;
    typedef enum logic [1:0] {PH_PRE, PH_BODY, PH_TAIL} seq_phase_e;

    // request vector bit positions; lower index = higher priority
    localparam int REQ_N    = 6;
    localparam int REQ_INIT = 0;
    localparam int REQ_REF  = 1;
    localparam int REQ_ORD  = 2;
    localparam int REQ_OWR  = 3;
    localparam int REQ_DOWN = 4;
    localparam int REQ_UP   = 5;

endpackage

// File: rtl/sdram_req_arb.sv
module sdram_req_arb
    import sdram_seq_pkg::*;
(
    input  logic [REQ_N-1:0] req,
    input  logic             idle,
    input  logic             pdn,
    output logic [REQ_N-1:0] grant,
    output logic             ignored_in_pdn
);
    logic [REQ_N-1:0] eligible;
    logic             found;

    always_comb begin
        if (pdn) begin
            eligible = req & (REQ_N'(1) << REQ_UP);
        end else if (idle) begin
            eligible = req & ~(REQ_N'(1) << REQ_UP);
        end else begin
            eligible = '0;
        end
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < REQ_N; i++) begin
            if (eligible[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        ignored_in_pdn = pdn && (|(req & ~(REQ_N'(1) << REQ_UP)));
    end

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R5: a running gap counts down by exactly one per cycle
    a_r5_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int PARAM_W   = 32,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int BANKS     = 4,
    parameter int AP_BIT    = 10,
    parameter int N_INITREF = 2,
    parameter int N_BURST   = 8,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 7,
    parameter int T_MRD     = 2,
    parameter int T_RCD     = 3,
    localparam int BA_W     = $clog2(BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_init,
    input  logic               cmd_refresh,
    input  logic               cmd_open_rd,
    input  logic               cmd_open_wr,
    input  logic               cmd_pwr_down,
    input  logic               cmd_pwr_up,
    input  logic [PARAM_W-1:0] param_word,
    input  logic [ROW_W-1:0]   mode_cfg,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [ROW_W-1:0]   sd_addr,
    output logic [BA_W-1:0]    sd_ba,
    output logic               sd_cke,
    output logic               busy,
    output logic               pd_err,
    output logic               rd_open,
    output logic               wr_open
);
    localparam int T_A   = (T_RP  > T_RFC) ? T_RP  : T_RFC;
    localparam int T_B   = (T_MRD > T_RCD) ? T_MRD : T_RCD;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;
    localparam int R_A   = (N_BURST > N_INITREF) ? N_BURST : N_INITREF;
    localparam int R_MAX = (R_A > BANKS) ? R_A : BANKS;
    localparam int REP_W = $clog2(R_MAX + 1);
    localparam int ROW_LO = COL_W + BA_W;

    typedef struct packed {
        seq_state_e           state;
        seq_kind_e            kind;
        seq_phase_e           phase;
        logic [REP_W-1:0]     rep;
        logic [ROW_W-1:0]     row;
        sd_cmd_e              cmd;
        logic [ROW_W-1:0]     addr;
        logic [BA_W-1:0]      ba;
        logic                 cke;
        logic                 busy;
        logic                 err;
        logic                 rd_open;
        logic                 wr_open;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    logic [REQ_N-1:0] req, grant;
    logic             arb_err, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [REP_W-1:0] body_len;

    assign req = {cmd_pwr_up, cmd_pwr_down, cmd_open_wr, cmd_open_rd, cmd_refresh, cmd_init};

    sdram_req_arb u_arb (
        .req            (req),
        .idle           (s_q.state == ST_IDLE),
        .pdn            (s_q.state == ST_PDN),
        .grant          (grant),
        .ignored_in_pdn (arb_err)
    );

    sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        case (s_q.kind)
            K_INIT:  body_len = REP_W'(N_INITREF);
            K_REF:   body_len = REP_W'(N_BURST);
            default: body_len = REP_W'(BANKS);
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.addr = '0;
        s_d.ba   = '0;
        s_d.err  = arb_err;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (s_q.state)
            ST_IDLE: begin
                if (|grant[REQ_OWR:REQ_INIT]) begin
                    s_d.state   = ST_RUN;
                    s_d.phase   = PH_PRE;
                    s_d.rep     = '0;
                    s_d.row     = param_word[ROW_LO +: ROW_W];
                    s_d.cmd     = CMD_PRE;
                    s_d.addr    = ROW_W'(1) << AP_BIT;
                    s_d.busy    = 1'b1;
                    s_d.rd_open = 1'b0;
                    s_d.wr_open = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(T_RP - 1);
                    if (grant[REQ_INIT])     s_d.kind = K_INIT;
                    else if (grant[REQ_REF]) s_d.kind = K_REF;
                    else if (grant[REQ_ORD]) s_d.kind = K_ORD;
                    else                     s_d.kind = K_OWR;
                end else if (grant[REQ_DOWN]) begin
                    s_d.state   = ST_PDN;
                    s_d.cke     = 1'b0;
                    s_d.rd_open = 1'b0;
                    s_d.wr_open = 1'b0;
                end
            end
            ST_PDN: begin
                if (grant[REQ_UP]) begin
                    s_d.state = ST_IDLE;
                    s_d.cke   = 1'b1;
                end
            end
            default: begin
                if (tmr_done) begin
                    if (s_q.phase == PH_PRE || (s_q.phase == PH_BODY && s_q.rep < body_len)) begin
                        s_d.phase = PH_BODY;
                        s_d.rep   = s_q.rep + 1'b1;
                        tmr_load  = 1'b1;
                        if (s_q.kind == K_ORD || s_q.kind == K_OWR) begin
                            s_d.cmd  = CMD_ACT;
                            s_d.addr = s_q.row;
                            s_d.ba   = BA_W'(s_q.rep);
                            tmr_val  = CNT_W'(T_RCD - 1);
                        end else begin
                            s_d.cmd  = CMD_REF;
                            tmr_val  = CNT_W'(T_RFC - 1);
                        end
                    end else if (s_q.phase == PH_BODY && s_q.kind == K_INIT) begin
                        s_d.phase = PH_TAIL;
                        s_d.cmd   = CMD_MRS;
                        s_d.addr  = mode_cfg;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(T_MRD - 1);
                    end else begin
                        s_d.state   = ST_IDLE;
                        s_d.busy    = 1'b0;
                        s_d.rd_open = (s_q.kind == K_ORD);
                        s_d.wr_open = (s_q.kind == K_OWR);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.kind  <= K_INIT;
            s_q.phase <= PH_PRE;
            s_q.cmd   <= CMD_NOP;
            s_q.cke   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = s_q.cmd;
    assign sd_addr = s_q.addr;
    assign sd_ba   = s_q.ba;
    assign sd_cke  = s_q.cke;
    assign busy    = s_q.busy;
    assign pd_err  = s_q.err;
    assign rd_open = s_q.rd_open;
    assign wr_open = s_q.wr_open;

    // R1: outside a sequence the command pins carry NOP
    a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

    // R4: every sequence opens with a precharge-all
    a_r4_start_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_PRE && sd_addr[AP_BIT]));

    // R8: clock enable low means no sequence and no command
    a_r8_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> (!busy && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

    // R9: an error pulse follows a cycle spent in power-down
    a_r9_err_after_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        pd_err |-> $past(!sd_cke));

    // R7: open flags exclusive and only outside sequences
    a_r7_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_open || wr_open) |-> (!busy && !(rd_open && wr_open)));

endmodule

// File: tb/test_sdram_seq_ctrl.sv
module test_sdram_seq_ctrl;

    localparam int TRP = 3, TRFC = 5, TMRD = 2, TRCD = 2;
    localparam logic [11:0] MODE = 12'h233;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] req = '0;
    logic [31:0] param_word = '0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, busy, pd_err, rd_open, wr_open;
    logic [11:0] sd_addr;
    logic [1:0] sd_ba;

    int checks = 0;
    int fails = 0;
    logic m_pdn = 1'b0, m_rd = 1'b0, m_wr = 1'b0;

    always #4 clk = ~clk;

    sdram_seq_ctrl #(.T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_RCD(TRCD)) i_sdram_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_init(req[0]), .cmd_refresh(req[1]), .cmd_open_rd(req[2]),
        .cmd_open_wr(req[3]), .cmd_pwr_down(req[4]), .cmd_pwr_up(req[5]),
        .param_word(param_word), .mode_cfg(MODE),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_cke(sd_cke), .busy(busy),
        .pd_err(pd_err), .rd_open(rd_open), .wr_open(wr_open)
    );

    function automatic int seq_len(int op);
        if (op == 0) return TRP + 2 * TRFC + TMRD;
        if (op == 1) return TRP + 8 * TRFC;
        return TRP + 4 * TRCD;
    endfunction

    // returns {cmd[3:0], ba[1:0], addr[11:0], busy}
    function automatic logic [18:0] seq_exp(int op, int j, logic [11:0] row);
        logic [3:0] c = 4'b0111;
        logic [1:0] b = 2'd0;
        logic [11:0] a = 12'd0;
        int k;
        if (j == 0) begin
            c = 4'b0010; a = 12'h400;
        end else if (j >= TRP) begin
            k = j - TRP;
            if (op == 0) begin
                if (k % TRFC == 0 && k / TRFC < 2) c = 4'b0001;
                else if (k == 2 * TRFC) begin c = 4'b0000; a = MODE; end
            end else if (op == 1) begin
                if (k % TRFC == 0 && k / TRFC < 8) c = 4'b0001;
            end else begin
                if (k % TRCD == 0 && k / TRCD < 4) begin
                    c = 4'b0011; a = row; b = 2'(k / TRCD);
                end
            end
        end
        return {c, b, a, (j < seq_len(op))};
    endfunction

    function automatic int pick(logic [5:0] m, logic pdn);
        if (pdn) return m[5] ? 5 : 6;
        for (int i = 0; i < 5; i++) if (m[i]) return i;
        return 6;
    endfunction

    task automatic check(input logic [22:0] exp_v, input string tag, input int j);
        logic [22:0] act_v;
        act_v = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, busy, sd_cke, pd_err, rd_open, wr_open};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, j, act_v, exp_v);
        end
    endtask

    task automatic do_op(input logic [5:0] mask, input logic [31:0] prm,
                         input int inj_raw, input logic [5:0] inj_mask, input string tag);
        int op, total, inj_j;
        logic seq, e_err, e_cke, e_rd, e_wr;
        logic [18:0] e;
        op    = pick(mask, m_pdn);
        seq   = (op < 4);
        total = seq ? seq_len(op) : 1;
        inj_j = inj_raw % total;
        e_err = m_pdn && (|mask[4:0]);
        @(negedge clk);
        req = mask;
        param_word = prm;
        for (int j = 0; j <= total; j++) begin
            @(negedge clk);
            if (seq) begin
                e = seq_exp(op, j, prm[23:12]);
                e_cke = 1'b1;
                e_rd = (j == total) && (op == 2);
                e_wr = (j == total) && (op == 3);
            end else begin
                e = {4'b0111, 2'd0, 12'd0, 1'b0};
                e_cke = (op == 4) ? 1'b0 : (op == 5) ? 1'b1 : !m_pdn;
                e_rd = (op == 4) ? 1'b0 : m_rd;
                e_wr = (op == 4) ? 1'b0 : m_wr;
            end
            check({e, e_cke, (j == 0) && e_err, e_rd, e_wr}, tag, j);
            req = (seq && j == inj_j) ? inj_mask : 6'b0;
        end
        if (seq) begin m_rd = (op == 2); m_wr = (op == 3); end
        else if (op == 4) begin m_pdn = 1'b1; m_rd = 1'b0; m_wr = 1'b0; end
        else if (op == 5) m_pdn = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [5:0] m;
        int r;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R10: reset state
        check({4'b0111, 2'd0, 12'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, "R10", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({4'b0111, 2'd0, 12'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, "R10", 1);
        // R6: all requests at once, init wins; R2 init trace
        do_op(6'b111111, 32'h00ABC123, 0, 6'b0, "R6 R2 R1");
        // R5: requests injected mid-refresh are ignored; R3 trace
        do_op(6'b000010, 32'h0, 4, 6'b011101, "R5 R3 R1");
        // R5: injection on the final busy cycle
        do_op(6'b000010, 32'h0, TRP + 8 * TRFC - 1, 6'b000001, "R5 R3");
        // R6: open-read wins over open-write and power-down; R4 R7
        do_op(6'b011100, 32'h00F5A3FF, 0, 6'b0, "R6 R4 R7");
        do_op(6'b001000, 32'h00123C00, 2, 6'b000100, "R4 R7 R5");
        // R8: power-up in idle has no effect
        do_op(6'b100000, 32'h0, 0, 6'b0, "R8 idle power-up");
        do_op(6'b010000, 32'h0, 0, 6'b0, "R8 power-down");
        // R9: ignored request in power-down
        do_op(6'b000010, 32'h0, 0, 6'b0, "R9");
        do_op(6'b010000, 32'h0, 0, 6'b0, "R9");
        // R8 R9: power-up together with other requests
        do_op(6'b100101, 32'h0, 0, 6'b0, "R8 R9");
        for (int n = 0; n < 250; n++) begin
            r = $urandom;
            if (r[3:0] < 4'd10) m = 6'b1 << (r[6:4] % 6);
            else m = 6'($urandom);
            do_op(m, $urandom, int'($urandom % 64), (r[7] ? 6'($urandom) : 6'b0),
                  "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule